// File: doc/BRIEF.md
# Pipelined Gated Weight Summation

This block forms a gated sum of a set of signed weights plus a bias, and saturates the result to a narrow signed word. Each weight has a 0/1 enable. A weight whose enable is high is added. A weight whose enable is low adds zero. The bias is always added. By default there are 22 weights of 9 bits and a 9-bit bias. The sum is carried at 14 bits and clamped into a 9-bit two's-complement result.

The sum is computed by a registered pairwise reduction tree. The first stage applies the enables and adds the weights in pairs, so 22 weights become 11 partial sums. The bias then joins as a twelfth operand. Later stages reduce 12 to 6, 6 to 3, 3 to 2 and 2 to 1. An operand with no partner is carried forward through a register. A final register applies the saturation. The block takes a complete input set on every clock and returns one result on every clock, six clocks later. A valid flag travels alongside the data.

Top module: `gated_sum_pipe`

## Requirements
- R1: Reset is synchronous and active low. A rising clock edge with `rst_n` low leaves `out_valid` at 0 and `result` at 0, and no sample captured before that edge ever produces a valid output.
- R2: Weight i is the signed two's-complement field `weights[9*i+8 : 9*i]`, and its enable is `enables[i]`. The result equals the bias plus the sum of every weight whose enable is 1, after the clamp of R7 to R9.
- R3: A sample captured at a rising edge with `in_valid` high appears on `result`, with `out_valid` high, just after the sixth rising edge that follows.
- R4: Samples presented on consecutive clocks each produce their own result on consecutive clocks, in order, with no gap.
- R5: `out_valid` is high for exactly those cycles that correspond, six edges earlier, to a capture with `in_valid` high. Idle input cycles produce no valid output.
- R6: A weight with its enable at 0 has no effect on the result, whatever its value, including the most negative value.
- R7: A sum above +255 gives a result of 9'b011111111.
- R8: A sum below -256 gives a result of 9'b100000000.
- R9: A sum from -256 to +255 inclusive appears unchanged as the low 9 bits.
- R10: The bias `bias` (signed, 9 bits) is added to the sample with which it was presented, even when the bias changes on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the current input set as a sample |
| weights | input | 198 | 22 signed 9-bit weights, weight i at bits 9*i+8 down to 9*i |
| enables | input | 22 | Per-weight 0/1 gate, bit i for weight i |
| bias | input | 9 | Signed bias added to every sample |
| out_valid | output | 1 | High when `result` holds a sample's sum |
| result | output | 9 | Saturated signed sum |

## Verification
The hardest situation to create is one where every stage of the tree holds a different sample at once. A wrong register count on the carried-forward operand, or on the bias path, only shows up then, because the operand then merges with a neighbouring sample. The stimulus therefore sends long back-to-back runs in which the weights, the enable density and the bias all change on every clock. Runs with idle gaps follow, and saturation boundaries are placed next to each other so that a clamp applied to the wrong sample is exposed. A reset issued while samples are still in flight checks that none of them surfaces afterwards.

// File: rtl/gsum_pkg.sv
package gsum_pkg;

    // Operand count at tree level k when level 0 holds first_ops operands.
    function automatic int ops_at(input int first_ops, input int k);
        int c;
        c = first_ops;
        for (int i = 0; i < k; i++) c = (c + 1) / 2;
        return c;
    endfunction

    // Number of pairwise levels needed to bring first_ops operands down to one.
    function automatic int depth_of(input int first_ops);
        int c;
        int d;
        c = first_ops;
        d = 0;
        while (c > 1) begin
            c = (c + 1) / 2;
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/gated_pair_add.sv
module gated_pair_add #(
    parameter int W_WT  = 9,
    parameter int W_ACC = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [W_WT-1:0]  wa,
    input  logic signed [W_WT-1:0]  wb,
    input  logic                    ea,
    input  logic                    eb,
    output logic signed [W_ACC-1:0] sum_q
);
    localparam int EXT = W_ACC - W_WT;

    logic signed [W_ACC-1:0] ga;
    logic signed [W_ACC-1:0] gb;

    // Gate by AND with the replicated enable, then add in the same stage.
    always_comb begin
        ga = {{EXT{wa[W_WT-1]}}, wa} & {W_ACC{ea}};
        gb = {{EXT{wb[W_WT-1]}}, wb} & {W_ACC{eb}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= ga + gb;
    end
endmodule

// File: rtl/pair_add_reg.sv
module pair_add_reg #(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= a + b;
    end
endmodule

// File: rtl/pipe_reg.sv
module pipe_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W_ACC = 14,
    parameter int W_OUT = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [W_ACC-1:0] sum,
    output logic signed [W_OUT-1:0] res_q
);
    localparam logic signed [W_ACC-1:0] HI_EXT = W_ACC'((2 ** (W_OUT - 1)) - 1);
    localparam logic signed [W_ACC-1:0] LO_EXT = W_ACC'(-(2 ** (W_OUT - 1)));
    localparam logic [W_OUT-1:0] HI_OUT = {1'b0, {(W_OUT-1){1'b1}}};
    localparam logic [W_OUT-1:0] LO_OUT = {1'b1, {(W_OUT-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n)             res_q <= '0;
        else if (sum > HI_EXT)  res_q <= HI_OUT;
        else if (sum < LO_EXT)  res_q <= LO_OUT;
        else                    res_q <= sum[W_OUT-1:0];
    end
endmodule

// File: rtl/gated_sum_pipe.sv
module gated_sum_pipe
    import gsum_pkg::*;
#(
    parameter int N_IN  = 22,
    parameter int W_WT  = 9,
    parameter int W_ACC = 14,
    parameter int W_OUT = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_IN*W_WT-1:0]     weights,
    input  logic [N_IN-1:0]          enables,
    input  logic signed [W_WT-1:0]   bias,
    output logic                     out_valid,
    output logic signed [W_OUT-1:0]  result
);
    localparam int N_PAIR = (N_IN + 1) / 2;       // partial sums after stage 1
    localparam int FIRST  = N_PAIR + 1;           // plus the bias operand
    localparam int NLEV   = depth_of(FIRST);      // pairwise levels after stage 1
    localparam int LAT    = NLEV + 2;             // stage 1 + tree + clamp

    logic [W_ACC-1:0] bias_ext;
    assign bias_ext = {{(W_ACC-W_WT){bias[W_WT-1]}}, bias};

    for (genvar k = 0; k <= NLEV; k++) begin : stg
        localparam int CNT = ops_at(FIRST, k);
        logic signed [W_ACC-1:0] v [CNT];

        if (k == 0) begin : g_first
            for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
                if (2 * j + 1 < N_IN) begin : g_two
                    gated_pair_add #(.W_WT(W_WT), .W_ACC(W_ACC)) u_add (
                        .clk   (clk),
                        .rst_n (rst_n),
                        .wa    (weights[(2*j)*W_WT +: W_WT]),
                        .wb    (weights[(2*j+1)*W_WT +: W_WT]),
                        .ea    (enables[2*j]),
                        .eb    (enables[2*j+1]),
                        .sum_q (v[j])
                    );
                end else begin : g_one
                    gated_pair_add #(.W_WT(W_WT), .W_ACC(W_ACC)) u_add (
                        .clk   (clk),
                        .rst_n (rst_n),
                        .wa    (weights[(2*j)*W_WT +: W_WT]),
                        .wb    ('0),
                        .ea    (enables[2*j]),
                        .eb    (1'b0),
                        .sum_q (v[j])
                    );
                end
            end
            // Bias delayed one stage so it joins its own sample.
            logic [W_ACC-1:0] bias_q;
            pipe_reg #(.W(W_ACC)) u_bias (
                .clk (clk), .rst_n (rst_n), .d (bias_ext), .q (bias_q)
            );
            assign v[N_PAIR] = bias_q;
        end else begin : g_tree
            localparam int PREV = ops_at(FIRST, k - 1);
            for (genvar j = 0; j < CNT; j++) begin : g_node
                if (2 * j + 1 < PREV) begin : g_add
                    pair_add_reg #(.W(W_ACC)) u_add (
                        .clk   (clk),
                        .rst_n (rst_n),
                        .a     (stg[k-1].v[2*j]),
                        .b     (stg[k-1].v[2*j+1]),
                        .sum_q (v[j])
                    );
                end else begin : g_carry
                    logic [W_ACC-1:0] cq;
                    pipe_reg #(.W(W_ACC)) u_carry (
                        .clk (clk), .rst_n (rst_n), .d (stg[k-1].v[2*j]), .q (cq)
                    );
                    assign v[j] = cq;
                end
            end
        end
    end

    sat_clamp #(.W_ACC(W_ACC), .W_OUT(W_OUT)) u_sat (
        .clk   (clk),
        .rst_n (rst_n),
        .sum   (stg[NLEV].v[0]),
        .res_q (result)
    );

    logic [LAT-1:0] vld_sr;
    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[LAT-2:0], in_valid};
    end
    assign out_valid = vld_sr[LAT-1];
endmodule

// File: rtl/gated_sum_pipe_chk.sv
module gated_sum_pipe_chk #(
    parameter int N_IN  = 22,
    parameter int W_WT  = 9,
    parameter int W_OUT = 9,
    parameter int LAT   = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [N_IN*W_WT-1:0]    weights,
    input logic [N_IN-1:0]         enables,
    input logic signed [W_WT-1:0]  bias,
    input logic                    out_valid,
    input logic signed [W_OUT-1:0] result
);
    localparam int HI = (2 ** (W_OUT - 1)) - 1;
    localparam int LO = -(2 ** (W_OUT - 1));

    int                      acc;
    logic signed [W_OUT-1:0] mdl;
    logic [LAT-1:0]          vq;
    logic [LAT-1:0][W_OUT-1:0] eq;

    always_comb begin
        acc = int'(bias);
        for (int i = 0; i < N_IN; i++)
            if (enables[i]) acc += int'($signed(weights[i*W_WT +: W_WT]));
        if (acc > HI)      mdl = W_OUT'(HI);
        else if (acc < LO) mdl = W_OUT'(LO);
        else               mdl = W_OUT'(acc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[LAT-2:0], in_valid};
        eq <= {eq[LAT-2:0], mdl};
    end

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R3 R4 R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[LAT-1]);

    // R2 R6 R7 R8 R9 R10
    sum_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> result == $signed(eq[LAT-1]));

    // R2
    result_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(result));
endmodule

bind gated_sum_pipe gated_sum_pipe_chk #(
    .N_IN (N_IN), .W_WT (W_WT), .W_OUT (W_OUT), .LAT (LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .weights   (weights),
    .enables   (enables),
    .bias      (bias),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/gated_sum_pipe_tb.sv
module gated_sum_pipe_tb;
    localparam int N   = 22;
    localparam int W   = 9;
    localparam int LAT = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [N*W-1:0]       weights = '0;
    logic [N-1:0]         enables = '0;
    logic signed [W-1:0]  bias = '0;
    logic                 out_valid;
    logic signed [W-1:0]  result;

    gated_sum_pipe u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .weights (weights),
        .enables (enables), .bias (bias), .out_valid (out_valid), .result (result)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct { int exp; int due; string tag; } exp_t;
    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int model(input logic [N*W-1:0] w, input logic [N-1:0] e,
                                 input logic signed [W-1:0] b);
        int s;
        s = int'(b);
        for (int i = 0; i < N; i++) if (e[i]) s += int'($signed(w[i*W +: W]));
        if (s > 255)  s = 255;
        if (s < -256) s = -256;
        return s;
    endfunction

    function automatic logic [N*W-1:0] fill(input int val);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(val);
        return r;
    endfunction

    task automatic send(input logic [N*W-1:0] w, input logic [N-1:0] e,
                        input logic signed [W-1:0] b, input string tag);
        exp_t x;
        @(negedge clk);
        weights  = w;
        enables  = e;
        bias     = b;
        in_valid = 1'b1;
        x.exp = model(w, e, b);
        x.due = cyc + LAT;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            weights  = {N{9'h0AB}};
            bias     = 9'sd77;
            enables  = '1;
        end
    endtask

    // Output monitor: every valid output matches the oldest expected sample at its due cycle.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    chk(int'(result) == x.exp, x.tag, int'(result), x.exp);
                    chk(cyc == x.due, {"R3 latency ", x.tag}, cyc, x.due);
                end
            end else if (q.size() != 0 && q[0].due <= cyc) begin
                chk(1'b0, {"R4 missing output ", q[0].tag}, 0, 1);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(result == '0, "R1 reset result", int'(result), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // Directed corners, back to back.
        send(fill(-256), '0, 9'sd37, "R6 disabled negative weights");
        send(fill(255), '0, -9'sd5, "R10 bias only");
        send(fill(255), '1, 9'sd0, "R7 all high");
        send(fill(-256), '1, 9'sd0, "R8 all low");
        send('0, '0, 9'sd255, "R9 upper bound");
        send('0, '0, -9'sd256, "R9 lower bound");
        send(fill(1), 22'h000001, 9'sd255, "R7 just above");
        send(fill(-1), 22'h200000, -9'sd256, "R8 just below");
        send(fill(10), 22'h155555, 9'sd0, "R2 alternate enables");
        send(fill(-7), 22'h3FFFFF, 9'sd100, "R9 negative in range");
        for (int i = 0; i < 8; i++)
            send('0, '0, W'(i * 31 - 120), "R10 changing bias");

        // Random back-to-back.
        for (int i = 0; i < 300; i++) begin
            logic [N*W-1:0] w;
            logic [N-1:0] e;
            for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom);
            e = N'($urandom);
            if (i % 3 == 1) e = e & N'($urandom) & N'($urandom);
            if (i % 5 == 2) for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom_range(0, 40) - 20);
            send(w, e, W'($urandom), "R4 back-to-back random");
        end

        // Random with idle gaps.
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            else begin
                logic [N*W-1:0] w;
                for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom_range(0, 60) - 30);
                send(w, N'($urandom), W'($urandom), "R5 gapped random");
            end
        end
        idle(LAT + 4);
        chk(q.size() == 0, "R3 all samples returned", q.size(), 0);

        // Reset with samples in flight.
        send(fill(3), '1, 9'sd1, "R1 flight a");
        send(fill(4), '1, 9'sd2, "R1 flight b");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        q.delete();
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid-run reset out_valid", int'(out_valid), 0);
        chk(result == '0, "R1 mid-run reset result", int'(result), 0);
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 no stale output", int'(out_valid), 0);
        end

        send(fill(-256), 22'h000000, -9'sd1, "R6 after reset");
        idle(LAT + 3);
        chk(q.size() == 0, "R3 final drain", q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule